// File: doc/BRIEF.md
# Priority Bus Arbitration Node

This block is the transmit-side contention logic of one node on a shared serial line where any node pulling the line low overrides every node that leaves it high (wired-AND). When asked to send, the node latches its identifier. It then places the identifier bits on the line one per bit-sample strobe, most significant bit first. At each strobe it compares the level it drives with the level it reads back from the line. The first disagreement means a higher-priority node is also sending. The node then releases the line (drives high) for the rest of the frame, flags the loss for one cycle, and waits quietly. It does not disturb the other transmission.

A node that reaches the end of the identifier with no disagreement owns the line and raises its won flag. It keeps that flag until the frame outcome (success or error) is reported. A node that lost starts the same identifier again on its own as soon as the current frame on the line is reported finished. Because low levels win, the numerically smallest identifier always prevails.

A transmit error count goes up by 8 for each reported error and down by 1 for each successful frame, with a floor at 0. When the count would exceed 255, the node goes off-bus. It then drives high, ignores send requests and does not participate until a recovery request clears the count.

Top module: `prio_arb_node`

## Requirements
- R1: In the cycle after an accepted start request, drive_tx carries identifier bit 10 (the MSB). Each bit_strobe that finds no disagreement moves drive_tx to the next lower bit.
- R2: A bit_strobe where bus_rx differs from drive_tx raises lost_pulse for exactly one cycle. From that cycle on, drive_tx stays 1 (recessive) until the node restarts.
- R3: Among nodes whose outputs are ANDed onto one line and which start together, the one with the numerically lowest identifier sets won after the 11th strobe. It never sees a disagreement, and every other node reports a loss.
- R4: A node that lost reloads its latched identifier when frame_end is pulsed and competes again. No new start request is needed.
- R5: start_req is ignored while the node is arbitrating, waiting after a loss, holding the line, or off-bus.
- R6: Each err_evt adds 8 to the error count. Each ok_evt without err_evt subtracts 1, but never below 0. err_evt takes precedence when both arrive in the same cycle.
- R7: bus_off is set in the cycle after the err_evt that takes the count above 255. While bus_off is 1, drive_tx is 1 and won is 0.
- R8: recover_req while off-bus clears bus_off and sets the count to 0 in the next cycle. recover_req has no effect at any other time.
- R9: A node holding won returns to idle, with won cleared, on the cycle after ok_evt or err_evt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request to send the identifier |
| ident | input | 11 | Identifier, lower value means higher priority |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| bus_rx | input | 1 | Line level sampled back from the shared bus |
| frame_end | input | 1 | Pulse: the frame currently on the line has finished |
| ok_evt | input | 1 | Pulse: own frame completed successfully |
| err_evt | input | 1 | Pulse: transmit error observed |
| recover_req | input | 1 | Pulse: leave the off-bus state |
| drive_tx | output | 1 | Level driven onto the line (1 = recessive) |
| lost_pulse | output | 1 | One-cycle pulse on loss of arbitration |
| won | output | 1 | High while this node owns the line after the identifier |
| bus_off | output | 1 | High while the node is off-bus |

## Verification
The embedded properties check, on every cycle, several local rules. A loss is only ever flagged on a strobe. A losing or off-bus node always drives recessive. won and lost_pulse never coincide. The drive level only changes on a strobe while arbitrating. Off-bus entry follows an error, it persists until recovery, and recovery takes effect in the next cycle. Only the bench scenarios can show system-level behaviour. That covers the smallest identifier winning among several nodes sharing an ANDed line, losers retrying after frame end and winning in priority order, and the exact error-count arithmetic around the 255 boundary, including the floor at zero.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_WON  = 2'd2,
    ST_LOST = 2'd3
  } arb_state_e;
endpackage

// File: rtl/arb_seq.sv
module arb_seq
  import arb_pkg::*;
#(
  parameter int ID_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic [ID_W-1:0] ident,
  input  logic            bit_strobe,
  input  logic            bus_rx,
  input  logic            frame_end,
  input  logic            done_evt,
  input  logic            halt,
  output logic            drive_tx,
  output logic            lost_pulse,
  output logic            won
);
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_W - 1);

  arb_state_e      state;
  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      id_q       <= '0;
      sh_q       <= '0;
      idx_q      <= '0;
      drive_tx   <= 1'b1;
      lost_pulse <= 1'b0;
      won        <= 1'b0;
    end else begin
      lost_pulse <= 1'b0;
      if (halt) begin
        state    <= ST_IDLE;
        drive_tx <= 1'b1;
        won      <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start_req) begin
              id_q     <= ident;
              sh_q     <= ident;
              drive_tx <= ident[ID_W-1];
              idx_q    <= '0;
              state    <= ST_ARB;
            end
          end
          ST_ARB: begin
            if (bit_strobe) begin
              if (bus_rx != drive_tx) begin
                state      <= ST_LOST;
                drive_tx   <= 1'b1;
                lost_pulse <= 1'b1;
              end else if (idx_q == LAST_IDX) begin
                state    <= ST_WON;
                won      <= 1'b1;
                drive_tx <= 1'b1;
              end else begin
                sh_q     <= sh_q << 1;
                drive_tx <= sh_q[ID_W-2];
                idx_q    <= idx_q + 1'b1;
              end
            end
          end
          ST_WON: begin
            if (done_evt) begin
              state <= ST_IDLE;
              won   <= 1'b0;
            end
          end
          ST_LOST: begin
            if (frame_end) begin
              sh_q     <= id_q;
              drive_tx <= id_q[ID_W-1];
              idx_q    <= '0;
              state    <= ST_ARB;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2
  loss_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    lost_pulse |-> $past(bit_strobe));

  // R2
  loser_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOST) |-> drive_tx);

  // R3
  won_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
    won |-> !lost_pulse);

  // R1
  drive_only_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_ARB) && $past(state == ST_ARB) && !$past(bit_strobe)) |-> $stable(drive_tx));
endmodule

// File: rtl/tx_err_tracker.sv
module tx_err_tracker #(
  parameter int ERR_INC   = 8,
  parameter int OFF_LIMIT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic ok_evt,
  input  logic recover_req,
  output logic bus_off,
  output logic entering_off
);
  localparam int CNT_W = $clog2(OFF_LIMIT + ERR_INC + 1);
  localparam logic [CNT_W-1:0] INC_V = CNT_W'(ERR_INC);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(OFF_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             off_nx;

  always_comb begin
    cnt_nx = cnt_q;
    off_nx = bus_off;
    if (bus_off) begin
      if (recover_req) begin
        cnt_nx = '0;
        off_nx = 1'b0;
      end
    end else if (err_evt) begin
      cnt_nx = cnt_q + INC_V;
      off_nx = (cnt_nx > LIM_V);
    end else if (ok_evt && (cnt_q != '0)) begin
      cnt_nx = cnt_q - 1'b1;
    end
  end

  assign entering_off = off_nx && !bus_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      bus_off <= 1'b0;
    end else begin
      cnt_q   <= cnt_nx;
      bus_off <= off_nx;
    end
  end

  // R7
  off_after_err_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_off) |-> $past(err_evt));

  // R8
  off_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_off && !recover_req) |=> bus_off);

  // R8
  recover_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_off && recover_req) |=> (!bus_off && cnt_q == '0));

  // R6
  no_growth_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_off && !err_evt) |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/prio_arb_node.sv
module prio_arb_node #(
  parameter int ID_W      = 11,
  parameter int ERR_INC   = 8,
  parameter int OFF_LIMIT = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic [ID_W-1:0] ident,
  input  logic            bit_strobe,
  input  logic            bus_rx,
  input  logic            frame_end,
  input  logic            ok_evt,
  input  logic            err_evt,
  input  logic            recover_req,
  output logic            drive_tx,
  output logic            lost_pulse,
  output logic            won,
  output logic            bus_off
);
  logic entering_off;
  logic halt;

  assign halt = bus_off || entering_off;

  tx_err_tracker #(
    .ERR_INC  (ERR_INC),
    .OFF_LIMIT(OFF_LIMIT)
  ) u_err (
    .clk         (clk),
    .rst         (rst),
    .err_evt     (err_evt),
    .ok_evt      (ok_evt),
    .recover_req (recover_req),
    .bus_off     (bus_off),
    .entering_off(entering_off)
  );

  arb_seq #(
    .ID_W(ID_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .ident     (ident),
    .bit_strobe(bit_strobe),
    .bus_rx    (bus_rx),
    .frame_end (frame_end),
    .done_evt  (ok_evt || err_evt),
    .halt      (halt),
    .drive_tx  (drive_tx),
    .lost_pulse(lost_pulse),
    .won       (won)
  );

  // R7
  off_recessive_chk: assert property (@(posedge clk) disable iff (rst)
    bus_off |-> (drive_tx && !won));
endmodule

// File: tb/prio_arb_node_tb.sv
module prio_arb_node_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int ID_W = 11;
  localparam logic [ID_W-1:0] IDS [N] = '{11'h65A, 11'h3C1, 11'h3C7};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strobe = 1'b0;
  logic frame_end = 1'b0;
  logic [N-1:0] start_v = '0, ok_v = '0, err_v = '0, rec_v = '0;
  logic [N-1:0] drv, lostv, wonv, offv;
  logic bus_line;

  assign bus_line = &drv;
  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_node
    prio_arb_node u_dut (
      .clk(clk), .rst(rst), .start_req(start_v[g]), .ident(IDS[g]),
      .bit_strobe(strobe), .bus_rx(bus_line), .frame_end(frame_end),
      .ok_evt(ok_v[g]), .err_evt(err_v[g]), .recover_req(rec_v[g]),
      .drive_tx(drv[g]), .lost_pulse(lostv[g]), .won(wonv[g]), .bus_off(offv[g])
    );
  end

  typedef struct { logic [N-1:0] won_m; logic [N-1:0] lost_m; } exp_t;
  exp_t exp_q[$];
  int total = 0;
  int fails = 0;
  logic chk_flag = 1'b0;
  logic [N-1:0] lost_acc = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] act);
    logic [N-1:0] m = '0;
    logic [ID_W-1:0] best = '1;
    bit found = 0;
    for (int i = 0; i < N; i++)
      if (act[i] && (!found || IDS[i] < best)) begin
        best = IDS[i]; m = '0; m[i] = 1'b1; found = 1;
      end
    return m;
  endfunction

  // monitor: gathers loss pulses, compares with scoreboard on request
  initial begin
    forever begin
      @(negedge clk);
      lost_acc = lost_acc | lostv;
      if (chk_flag) begin
        exp_t e;
        e = exp_q.pop_front();
        check(wonv == e.won_m, "R3 won mask", 32'(wonv), 32'(e.won_m));
        check(lost_acc == e.lost_m, "R2 lost mask", 32'(lost_acc), 32'(e.lost_m));
        check((drv & e.lost_m) == e.lost_m, "R2 losers recessive", 32'(drv), 32'(e.lost_m));
        lost_acc = '0;
        chk_flag = 1'b0;
      end
    end
  end

  task automatic strobes(input int watch, input logic [ID_W-1:0] wid, input bit poke, input bit expect_high);
    for (int k = 0; k < ID_W; k++) begin
      repeat (2) @(negedge clk);
      if (watch >= 0) begin
        if (expect_high) check(drv[watch] == 1'b1, "R7 off-bus drives recessive", 32'(drv[watch]), 32'd1);
        else check(drv[watch] == wid[ID_W-1-k], "R1 bit order", 32'(drv[watch]), 32'(wid[ID_W-1-k]));
      end
      if (poke && k == 4) start_v[0] = 1'b1;
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      start_v[0] = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic round(input logic [N-1:0] act, input int watch, input bit poke);
    exp_t e;
    e.won_m = lowest(act);
    e.lost_m = act & ~e.won_m;
    exp_q.push_back(e);
    strobes(watch, (watch >= 0) ? IDS[watch] : '0, poke, 1'b0);
    #1 chk_flag = 1'b1;
    wait (!chk_flag);
  endtask

  task automatic finish_frame(input logic [N-1:0] winner);
    @(negedge clk);
    ok_v = winner; frame_end = 1'b1;
    @(negedge clk);
    ok_v = '0; frame_end = 1'b0;
    check(wonv == '0, "R9 won cleared after ok", 32'(wonv), 32'd0);
  endtask

  task automatic errs(input int n);
    @(negedge clk);
    err_v[0] = 1'b1;
    repeat (n) @(negedge clk);
    err_v[0] = 1'b0;
  endtask

  task automatic oks(input int n);
    @(negedge clk);
    ok_v[0] = 1'b1;
    repeat (n) @(negedge clk);
    ok_v[0] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(drv == '1, "R1 reset drive recessive", 32'(drv), 32'h7);
    check(wonv == '0 && lostv == '0, "R3 reset flags", 32'({wonv, lostv}), 32'd0);
    check(offv == '0, "R7 reset not off-bus", 32'(offv), 32'd0);

    // three nodes start together; node 0 re-requests mid-round (R5)
    start_v = '1;
    @(negedge clk);
    start_v = '0;
    round(3'b111, -1, 1'b1);
    finish_frame(lowest(3'b111));
    // R4: losers retry on their own
    round(3'b101, -1, 1'b0);
    finish_frame(lowest(3'b101));
    round(3'b001, 0, 1'b0);
    finish_frame(3'b001);

    // error counter on node 0
    oks(5);
    errs(31);
    check(offv[0] == 1'b0, "R6 floor at zero, 248 not off", 32'(offv[0]), 32'd0);
    oks(1);
    errs(1);
    check(offv[0] == 1'b0, "R6 decrement gives 255 not off", 32'(offv[0]), 32'd0);
    errs(1);
    check(offv[0] == 1'b1, "R7 above 255 off-bus", 32'(offv[0]), 32'd1);
    check(drv[0] == 1'b1, "R7 off-bus recessive", 32'(drv[0]), 32'd1);

    // R5: start ignored while off-bus
    @(negedge clk);
    start_v[0] = 1'b1;
    @(negedge clk);
    start_v[0] = 1'b0;
    strobes(0, '0, 1'b0, 1'b1);
    check(wonv[0] == 1'b0, "R5 no win while off-bus", 32'(wonv[0]), 32'd0);
    check(lostv[0] == 1'b0, "R5 no loss while off-bus", 32'(lostv[0]), 32'd0);

    @(negedge clk);
    rec_v[0] = 1'b1;
    @(negedge clk);
    rec_v[0] = 1'b0;
    check(offv[0] == 1'b0, "R8 recovery clears off-bus", 32'(offv[0]), 32'd0);
    errs(31);
    check(offv[0] == 1'b0, "R8 count cleared by recovery", 32'(offv[0]), 32'd0);
    errs(1);
    check(offv[0] == 1'b1, "R8 off-bus again at 256", 32'(offv[0]), 32'd1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule